// File: doc/BRIEF.md
# Programmable CPU Clock Generator

This block derives a square-wave clock for a small processor from a 16 MHz reference. The output rate is chosen from a ladder of nineteen settings running from 1 Hz to 1 MHz. The ladder steps 1, 2, 5 in every decade. The high and low halves of every output period are always equal. An operator moves along the ladder with a quadrature rotary encoder. Alternatively, a two-bit preset switch jumps straight to one of three fixed rates. The half-period in reference cycles of the selected setting is presented on an output so that an external display can show it.

Two operating modes are offered. In automatic mode the output runs continuously at the selected rate. In manual mode the output rests low, and each debounced press of a step button produces exactly one clock pulse, so that the processor can be walked through its bus cycles by hand. Rate changes and mode changes are applied only at output edges, so the processor never sees a shortened half-period.

Top module: `cpu_clkgen`

## Requirements
- R1: While and directly after reset the output is low, the generator is in manual mode, and the setting index is the top of the ladder (1 MHz, half-period 8).
- R2: Setting index i (0 to 18) selects the rate m x 10^(i/3) Hz, where m is 1, 2 or 5 for i mod 3 equal to 0, 1 or 2. Its half-period is REF_HZ/2 divided by that rate. `divOut` always shows the half-period of the selected index, so index 0 shows 8,000,000 and index 18 shows 8.
- R3: In automatic mode the output is a square wave whose high and low phases each last exactly the active half-period in reference cycles.
- R4: Automatic mode is seen two cycles after `runMode` rises. The output then stays low for one full half-period before its first rise, so the first rise comes H+3 cycles after the input changes. When `runMode` falls, the output finishes its current phase and a full low phase, and then it stays low with no further rise.
- R5: A new setting takes effect only at the next output edge. A phase already in progress keeps its old length.
- R6: On a rising edge of the synchronized encoder A input, the index goes up by one if B is low and down by one if B is high. The index saturates at 0 and 18 and never moves more than one place per edge.
- R7: `presetSw` code 0 leaves the encoder in control. Codes 1, 2 and 3 force the index to 6 (100 Hz), 12 (10 kHz) and 18 (1 MHz). Encoder edges are ignored while the code is not 0. After the code returns to 0, the encoder continues from the preset index.
- R8: The step button is synchronized and must hold a new level for DEB_CYCLES (256) consecutive cycles to be accepted. A press shorter than that gives no pulse. An accepted press starts its pulse DEB_CYCLES+3 cycles after the button changes.
- R9: In manual mode each accepted press gives exactly one pulse: high for STEP_HALF (8) cycles, then low for STEP_HALF cycles. Releasing the button gives nothing. In automatic mode presses have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16 MHz reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| encA | input | 1 | Rotary encoder channel A (asynchronous) |
| encB | input | 1 | Rotary encoder channel B (asynchronous) |
| stepBtn | input | 1 | Single-step push button, high when pressed (asynchronous) |
| runMode | input | 1 | 1 = automatic free-running, 0 = manual stepping |
| presetSw | input | 2 | Preset rate switch code; 0 hands control to the encoder |
| clkOut | output | 1 | Generated processor clock |
| divOut | output | 23 | Half-period in reference cycles of the selected setting |

## Verification
The hardest case to reach is a setting change that lands in the middle of a running phase. A close second is a drop of `runMode` that arrives while the output is high, close to a phase boundary. Both depend on where the two-cycle synchronizer delay falls against the divider count. The stimulus turns the encoder one detent while the output runs at the 8-cycle half-period, and it releases automatic mode just after a rising output edge. A behavioural model tracks the exact cycle of every output edge, so any shortened or stretched phase shows up at once. The debounce window is reached by holding the button both shorter and longer than 256 cycles, in manual mode and in automatic mode.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_STEP_HI,
    ST_STEP_LO
  } clkgenState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // reload the half-period counter
    logic useStep;  // reload with the fixed step width instead of the setting
    logic flip;     // invert the output level
  } clkgenStrobe_t;

  // Half-period in reference cycles for ladder index idx (1-2-5 per decade)
  function automatic int halfPeriodOf(input int refHz, input int idx);
    int rate;
    case (idx % 3)
      0:       rate = 1;
      1:       rate = 2;
      default: rate = 5;
    endcase
    for (int d = 0; d < idx / 3; d++) rate = rate * 10;
    return (refHz / 2) / rate;
  endfunction

endpackage

// File: rtl/clkgen_inputs.sv
module clkgen_inputs #(
  parameter int NUM_STEPS  = 19,
  parameter int IDX_W      = 5,
  parameter int RESET_IDX  = 18,
  parameter int DEB_CYCLES = 256,
  parameter int PRESET_LO  = 6,
  parameter int PRESET_MID = 12,
  parameter int PRESET_HI  = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             encA,
  input  logic             encB,
  input  logic             stepBtn,
  input  logic             runMode,
  input  logic [1:0]       presetSw,
  output logic             runReq,
  output logic             stepEvt,
  output logic [1:0]       presetCode,
  output logic [IDX_W-1:0] selIdx
);
  localparam int RAW_W = 6;
  localparam int DEB_W = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
  localparam logic [IDX_W-1:0] IDX_MAX  = IDX_W'(NUM_STEPS - 1);
  localparam logic [DEB_W-1:0] DEB_LAST = DEB_W'(DEB_CYCLES - 1);

  logic [RAW_W-1:0] meta, synced;
  logic             aPrev;
  logic             detentUp, detentDown;
  logic [IDX_W-1:0] presetIdx;
  logic             btnStable;
  logic [DEB_W-1:0] debCnt;

  // Two-stage synchronizer for all asynchronous inputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta   <= '0;
      synced <= '0;
    end else begin
      meta   <= {presetSw, runMode, stepBtn, encB, encA};
      synced <= meta;
    end
  end

  assign runReq     = synced[3];
  assign presetCode = synced[5:4];

  // Encoder: one step per rising edge of A, direction from B
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) aPrev <= 1'b0;
    else       aPrev <= synced[0];
  end

  assign detentUp   = synced[0] & ~aPrev & ~synced[1];
  assign detentDown = synced[0] & ~aPrev &  synced[1];

  always_comb begin
    case (presetCode)
      2'd1:    presetIdx = IDX_W'(PRESET_LO);
      2'd2:    presetIdx = IDX_W'(PRESET_MID);
      default: presetIdx = IDX_W'(PRESET_HI);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selIdx <= IDX_W'(RESET_IDX);
    end else if (presetCode != 2'd0) begin
      selIdx <= presetIdx;
    end else if (detentUp && selIdx != IDX_MAX) begin
      selIdx <= selIdx + 1'b1;
    end else if (detentDown && selIdx != '0) begin
      selIdx <= selIdx - 1'b1;
    end
  end

  // Step button debounce: a new level must persist DEB_CYCLES cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      btnStable <= 1'b0;
      debCnt    <= '0;
      stepEvt   <= 1'b0;
    end else if (synced[2] == btnStable) begin
      debCnt  <= '0;
      stepEvt <= 1'b0;
    end else if (debCnt == DEB_LAST) begin
      btnStable <= synced[2];
      debCnt    <= '0;
      stepEvt   <= synced[2];
    end else begin
      debCnt  <= debCnt + 1'b1;
      stepEvt <= 1'b0;
    end
  end

endmodule

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
  import clkgen_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          runReq,
  input  logic          stepEvt,
  input  logic          term,
  input  logic          outLvl,
  output clkgenStrobe_t strobe,
  output logic          idle
);
  clkgenState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (runReq) begin
          strobe.load = 1'b1;
          nextState   = ST_RUN;
        end else if (stepEvt) begin
          strobe.load    = 1'b1;
          strobe.useStep = 1'b1;
          strobe.flip    = 1'b1;
          nextState      = ST_STEP_HI;
        end
      end
      ST_RUN: begin
        if (term) begin
          if (!outLvl && !runReq) begin
            nextState = ST_IDLE;          // low phase complete: stop here
          end else begin
            strobe.flip = 1'b1;
            strobe.load = 1'b1;           // picks up any new setting
          end
        end
      end
      ST_STEP_HI: begin
        if (term) begin
          strobe.flip    = 1'b1;
          strobe.load    = 1'b1;
          strobe.useStep = 1'b1;
          nextState      = ST_STEP_LO;
        end
      end
      ST_STEP_LO: begin
        if (term) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign idle = (state == ST_IDLE);

endmodule

// File: rtl/clkgen_dp.sv
module clkgen_dp
  import clkgen_pkg::*;
#(
  parameter int REF_HZ    = 16_000_000,
  parameter int NUM_STEPS = 19,
  parameter int IDX_W     = 5,
  parameter int DIV_W     = 23,
  parameter int STEP_HALF = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  clkgenStrobe_t    strobe,
  input  logic [IDX_W-1:0] selIdx,
  output logic             term,
  output logic             outLvl,
  output logic [DIV_W-1:0] selHalf
);
  localparam int TAB_N = 1 << IDX_W;
  localparam logic [DIV_W-1:0] STEP_LOAD = DIV_W'(STEP_HALF - 1);

  logic [DIV_W-1:0] halfTab [TAB_N];
  logic [DIV_W-1:0] cnt;

  // Constant ladder; unused index codes repeat the top entry
  for (genvar g = 0; g < TAB_N; g++) begin : gLadder
    localparam int ENTRY = (g < NUM_STEPS) ? g : NUM_STEPS - 1;
    assign halfTab[g] = DIV_W'(halfPeriodOf(REF_HZ, ENTRY));
  end

  assign selHalf = halfTab[selIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      outLvl <= 1'b0;
    end else begin
      if (strobe.load)   cnt <= strobe.useStep ? STEP_LOAD : selHalf - 1'b1;
      else if (cnt != '0) cnt <= cnt - 1'b1;
      if (strobe.flip)   outLvl <= ~outLvl;
    end
  end

  assign term = (cnt == '0);

endmodule

// File: rtl/cpu_clkgen.sv
module cpu_clkgen
  import clkgen_pkg::*;
#(
  parameter int REF_HZ     = 16_000_000,
  parameter int DECADES    = 6,
  parameter int STEP_HALF  = 8,
  parameter int DEB_CYCLES = 256,
  parameter int RESET_IDX  = 3 * DECADES,
  parameter int PRESET_LO  = 6,
  parameter int PRESET_MID = 12,
  parameter int PRESET_HI  = 3 * DECADES,
  localparam int NUM_STEPS = 3 * DECADES + 1,
  localparam int IDX_W     = $clog2(NUM_STEPS),
  localparam int DIV_W     = $clog2(REF_HZ / 2 + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             encA,
  input  logic             encB,
  input  logic             stepBtn,
  input  logic             runMode,
  input  logic [1:0]       presetSw,
  output logic             clkOut,
  output logic [DIV_W-1:0] divOut
);
  logic             runReq, stepEvt, term, ctrlIdle;
  logic [1:0]       presetCode;
  logic [IDX_W-1:0] selIdx;
  clkgenStrobe_t    strobe;

  clkgen_inputs #(
    .NUM_STEPS(NUM_STEPS), .IDX_W(IDX_W), .RESET_IDX(RESET_IDX),
    .DEB_CYCLES(DEB_CYCLES), .PRESET_LO(PRESET_LO),
    .PRESET_MID(PRESET_MID), .PRESET_HI(PRESET_HI)
  ) uInputs (
    .clk(clk), .rstN(rstN), .encA(encA), .encB(encB), .stepBtn(stepBtn),
    .runMode(runMode), .presetSw(presetSw), .runReq(runReq),
    .stepEvt(stepEvt), .presetCode(presetCode), .selIdx(selIdx)
  );

  clkgen_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .runReq(runReq), .stepEvt(stepEvt),
    .term(term), .outLvl(clkOut), .strobe(strobe), .idle(ctrlIdle)
  );

  clkgen_dp #(
    .REF_HZ(REF_HZ), .NUM_STEPS(NUM_STEPS), .IDX_W(IDX_W),
    .DIV_W(DIV_W), .STEP_HALF(STEP_HALF)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selIdx(selIdx),
    .term(term), .outLvl(clkOut), .selHalf(divOut)
  );

endmodule

// File: rtl/clkgen_checks.sv
module clkgen_checks #(
  parameter int IDX_W     = 5,
  parameter int NUM_STEPS = 19
) (
  input logic             clk,
  input logic             rstN,
  input logic             clkOut,
  input logic             term,
  input logic             idle,
  input logic             presetActive,
  input logic [IDX_W-1:0] selIdx
);

  AST_RESET_OUT_LOW: assert property (@(posedge clk) !rstN |=> !clkOut); // R1

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(selIdx) <= NUM_STEPS - 1); // R6

  AST_IDX_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(presetActive) && !$stable(selIdx)) |->
      (selIdx == $past(selIdx) + 1'b1 || $past(selIdx) == selIdx + 1'b1)); // R6

  AST_EDGE_AT_TERMINAL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(clkOut) |-> $past(term)); // R3

  AST_IDLE_OUT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> !clkOut); // R9

endmodule

bind cpu_clkgen clkgen_checks #(.IDX_W(IDX_W), .NUM_STEPS(NUM_STEPS)) uChecks (
  .clk(clk), .rstN(rstN), .clkOut(clkOut), .term(term), .idle(ctrlIdle),
  .presetActive(presetCode != 2'd0), .selIdx(selIdx)
);

// File: tb/sim_cpu_clkgen.sv
module sim_cpu_clkgen;
  localparam int REF_HZ = 16_000_000;
  localparam int NSTEP  = 19;
  localparam int SHALF  = 8;
  localparam int DEB    = 256;

  logic clk = 1'b0, rstN = 1'b0;
  logic encA = 1'b0, encB = 1'b0, stepBtn = 1'b0, runMode = 1'b0;
  logic [1:0] presetSw = 2'd0;
  logic clkOut;
  logic [22:0] divOut;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  cpu_clkgen u0 (
    .clk(clk), .rstN(rstN), .encA(encA), .encB(encB), .stepBtn(stepBtn),
    .runMode(runMode), .presetSw(presetSw), .clkOut(clkOut), .divOut(divOut)
  );

  always #2 clk = ~clk;  // 250 MHz

  // Ladder from R2
  function automatic int expHalf(int idx);
    int rate;
    rate = (idx % 3 == 0) ? 1 : ((idx % 3 == 1) ? 2 : 5);
    for (int d = 0; d < idx / 3; d++) rate = rate * 10;
    return (REF_HZ / 2) / rate;
  endfunction

  // Preset codes from R7
  function automatic int presetIdx(int code);
    return (code == 1) ? 6 : ((code == 2) ? 12 : 18);
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [5:0] mP1 = '0, mP2 = '0;
  bit mAPrev = 0, mDeb = 0, mEvt = 0, mOut = 0;
  int mIdx = 18, mDebCnt = 0, mSt = 0, mCnt = 0;

  always @(posedge clk) begin
    bit rise, bS, run, btn, nDeb, nEvt, nOut, term;
    int pres, nIdx, nDebCnt, nSt, nCnt;
    if (!rstN) begin
      mP1 = '0; mP2 = '0; mAPrev = 0; mDeb = 0; mEvt = 0; mOut = 0;
      mIdx = 18; mDebCnt = 0; mSt = 0; mCnt = 0;
    end else begin
      rise = mP2[0] && !mAPrev; bS = mP2[1]; btn = mP2[2]; run = mP2[3];
      pres = int'(mP2[5:4]);
      nIdx = mIdx;
      if (pres != 0) nIdx = presetIdx(pres);
      else if (rise && !bS && mIdx < NSTEP - 1) nIdx = mIdx + 1;
      else if (rise && bS && mIdx > 0) nIdx = mIdx - 1;
      nDeb = mDeb; nDebCnt = 0; nEvt = 0;
      if (btn != mDeb) begin
        if (mDebCnt == DEB - 1) begin nDeb = btn; nEvt = btn; end
        else nDebCnt = mDebCnt + 1;
      end
      term = (mCnt == 0);
      nSt = mSt; nOut = mOut; nCnt = (mCnt > 0) ? mCnt - 1 : 0;
      case (mSt)
        0: if (run) begin nCnt = expHalf(mIdx) - 1; nSt = 1; end
           else if (mEvt) begin nCnt = SHALF - 1; nOut = 1; nSt = 2; end
        1: if (term) begin
             if (!mOut && !run) nSt = 0;
             else begin nOut = !mOut; nCnt = expHalf(mIdx) - 1; end
           end
        2: if (term) begin nOut = 0; nCnt = SHALF - 1; nSt = 3; end
        default: if (term) nSt = 0;
      endcase
      mAPrev = mP2[0]; mP2 = mP1; mP1 = {presetSw, runMode, stepBtn, encB, encA};
      mIdx = nIdx; mDeb = nDeb; mDebCnt = nDebCnt; mEvt = nEvt;
      mSt = nSt; mCnt = nCnt; mOut = nOut;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (clkOut !== mOut) begin
        errors++;
        $display("FAIL R3 clock output at %0t: got %0b expected %0b", $time, clkOut, mOut);
      end
      checks++;
      if (int'(divOut) != expHalf(mIdx)) begin
        errors++;
        $display("FAIL R2 divider display at %0t: got %0d expected %0d", $time, divOut, expHalf(mIdx));
      end
    end
  end

  // Rising-edge counter on the output
  int rises = 0;
  bit lastOut = 0;
  always @(negedge clk) begin
    if (clkOut && !lastOut) rises++;
    lastOut = clkOut;
  end

  task automatic check(string tag, int got, int exp, string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic detent(bit down);
    encB = down;
    repeat (3) @(negedge clk);
    encA = 1'b1;
    repeat (4) @(negedge clk);
    encA = 1'b0;
    repeat (3) @(negedge clk);
    encB = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic measurePhase(output int len);
    bit lvl;
    lvl = clkOut;
    while (clkOut == lvl) @(negedge clk);
    lvl = clkOut;
    len = 0;
    while (clkOut == lvl) begin @(negedge clk); len++; end
  endtask

  initial begin
    int n, len, r0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", int'(clkOut), 0, "output after reset");
    check("R1", int'(divOut), 8, "reset setting half-period");
    r0 = rises;
    repeat (50) @(negedge clk);
    check("R1", rises - r0, 0, "no pulses in manual idle");

    // Encoder and ladder
    detent(1'b0); detent(1'b0);
    check("R6", int'(divOut), 8, "saturate at top");
    detent(1'b1);
    check("R6", int'(divOut), 16, "one detent down");
    for (int i = 0; i < 17; i++) detent(1'b1);
    check("R2", int'(divOut), 8_000_000, "index 0 half-period");
    detent(1'b1);
    check("R6", int'(divOut), 8_000_000, "saturate at bottom");

    // Presets
    presetSw = 2'd1; repeat (6) @(negedge clk);
    check("R7", int'(divOut), 80_000, "preset code 1");
    detent(1'b1);
    check("R7", int'(divOut), 80_000, "encoder ignored under preset");
    presetSw = 2'd2; repeat (6) @(negedge clk);
    check("R7", int'(divOut), 800, "preset code 2");
    presetSw = 2'd3; repeat (6) @(negedge clk);
    check("R7", int'(divOut), 8, "preset code 3");
    presetSw = 2'd0; repeat (4) @(negedge clk);
    detent(1'b1);
    check("R7", int'(divOut), 16, "encoder resumes from preset");
    detent(1'b0);
    check("R6", int'(divOut), 8, "one detent up");

    // Automatic mode start
    runMode = 1'b1;
    n = 0;
    while (!clkOut) begin @(negedge clk); n++; end
    check("R4", n, 8 + 3, "cycles to first rise");
    for (int i = 0; i < 4; i++) begin
      measurePhase(len);
      check("R3", len, 8, "phase length at 1 MHz");
    end

    // Change setting mid-run
    detent(1'b1);
    measurePhase(len);
    checks++;
    if (len != 8 && len != 16) begin
      errors++;
      $display("FAIL R5 transition phase: got %0d expected 8 or 16", len);
    end
    for (int i = 0; i < 3; i++) begin
      measurePhase(len);
      check("R5", len, 16, "phase length after change");
    end

    // Stop while output high
    while (!clkOut) @(negedge clk);
    @(negedge clk);
    runMode = 1'b0;
    while (clkOut) @(negedge clk);
    r0 = rises;
    repeat (200) @(negedge clk);
    check("R4", rises - r0, 0, "no rise after leaving automatic");
    check("R4", int'(clkOut), 0, "output rests low");

    // Short press rejected
    r0 = rises;
    stepBtn = 1'b1; repeat (100) @(negedge clk);
    stepBtn = 1'b0; repeat (400) @(negedge clk);
    check("R8", rises - r0, 0, "short press rejected");

    // Accepted press
    r0 = rises;
    stepBtn = 1'b1;
    n = 0;
    while (!clkOut && n < 2000) begin @(negedge clk); n++; end
    check("R8", n, DEB + 3, "press-to-pulse latency");
    len = 0;
    while (clkOut && len < 2000) begin @(negedge clk); len++; end
    check("R9", len, SHALF, "step pulse high width");
    len = 0;
    while (!clkOut && len < SHALF + 2) begin @(negedge clk); len++; end
    check("R9", len, SHALF + 2, "no second pulse while held");
    repeat (400) @(negedge clk);
    stepBtn = 1'b0; repeat (400) @(negedge clk);
    check("R9", rises - r0, 1, "exactly one pulse per press");

    // Press during automatic mode
    runMode = 1'b1;
    measurePhase(len);
    stepBtn = 1'b1; repeat (300) @(negedge clk);
    stepBtn = 1'b0;
    measurePhase(len);
    check("R9", len, 16, "press ignored while running");
    repeat (300) @(negedge clk);
    measurePhase(len);
    check("R3", len, 16, "phase length at 500 kHz");
    runMode = 1'b0;
    repeat (80) @(negedge clk);
    check("R4", int'(clkOut), 0, "stopped low at end");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100_000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL R3 watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule